// File: doc/BRIEF.md
# Delayed Gate Window Generator

The block turns an asynchronous timing strobe into a clean, clock-aligned gate window. The strobe is brought into the clock domain through a flop chain, its rising edge starts a gate sequence, and a single down-counter times the start delay, then the window itself, and then the closing delay.

The window can be formed in one of two ways. In follow mode, the gate stays open for as long as the strobe stays high. A separate delay can be set for the opening edge and for the closing edge. In timed mode, the gate opens after the start delay and stays open for a programmed number of clock cycles. Timed mode does not look at the strobe's falling edge or at the closing delay. A strobe edge that arrives while a sequence is still running is dropped. All counts are in clock cycles of 8 ns. The configuration inputs must be held steady while a sequence runs.

Top module: `gate_gen`

## Requirements
- R1: While rst_ni is low, gate_o and gate_stat_o are low. The block then waits idle for a new strobe rising edge.
- R2: With a start delay of 0, gate_o goes high on the second rising clock edge after the edge that first samples trig_i high.
- R3: A start delay of S cycles moves the gate's opening edge exactly S clock edges later than in R2.
- R4: With mode_i = 0 (follow mode) and a stop delay of P, gate_o goes low on the edge (2 + P) clock edges after the edge that first samples trig_i low.
- R5: With mode_i = 1 (timed mode) and len_i = L > 0, gate_o stays high for exactly L clock cycles. The strobe's falling edge has no effect on it, and neither has stop_dly_i.
- R6: With mode_i = 1 and len_i = 0, a strobe produces no gate at all.
- R7: In follow mode the value of len_i has no effect on the gate.
- R8: A strobe rising edge that is seen while a sequence is in progress is ignored. A strobe that is still high when the sequence ends does not start a new sequence until it goes low and then high again.
- R9: gate_stat_o equals gate_o on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Asynchronous timing strobe |
| mode_i | input | 1 | 0 = follow mode, 1 = timed mode |
| len_i | input | CNT_W | Window length in cycles for timed mode |
| start_dly_i | input | CNT_W | Delay, in cycles, from strobe rise to gate open |
| stop_dly_i | input | CNT_W | Delay, in cycles, from strobe fall to gate close (follow mode) |
| gate_o | output | 1 | Gate window |
| gate_stat_o | output | 1 | Current gate level, for status readout |

## Verification
The hardest condition to reach is a second strobe edge that lands inside a sequence that is still running. Two cases matter: during a timed window, and during the closing delay in follow mode. A strobe held high past the end of a timed window is just as hard. Directed sequences place a second pulse at known offsets inside these windows, and also hold the strobe high beyond the window. Random sequences with a fixed seed then sweep the mode, the delays, the length and the pulse width. Every cycle is compared against a window computed by a bench function.

// File: rtl/gate_gen_pkg.sv
package gate_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_OPEN  = 2'd2,
    ST_HOLD  = 2'd3
  } gate_state_e;

  localparam logic MODE_FOLLOW = 1'b0;
  localparam logic MODE_TIMED  = 1'b1;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/gate_edge.sv
module gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/gate_cnt.sv
module gate_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/gate_gen.sv
module gate_gen
  import gate_gen_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] start_dly_i,
  input  logic [CNT_W-1:0] stop_dly_i,
  output logic             gate_o,
  output logic             gate_stat_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  gate_state_e      state_q, state_d;
  logic             trig_lvl, trig_rise;
  logic             cnt_ld, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             gate_q, gate_d;
  logic             timed, open_ok;

  gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trig_i), .q_o(trig_lvl)
  );

  gate_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(trig_lvl), .rise_o(trig_rise)
  );

  gate_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_ld), .load_val_i(cnt_val),
    .dec_i(cnt_dec), .zero_o(cnt_zero)
  );

  assign timed   = (mode_i == MODE_TIMED);
  assign open_ok = !(timed && len_i == '0);

  always_comb begin
    state_d = state_q;
    cnt_ld  = 1'b0;
    cnt_dec = 1'b0;
    cnt_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_rise) begin
          if (start_dly_i != '0) begin
            state_d = ST_START;
            cnt_ld  = 1'b1;
            cnt_val = start_dly_i - ONE;
          end else if (open_ok) begin
            state_d = ST_OPEN;
            cnt_ld  = timed;
            cnt_val = len_i - ONE;
          end
        end
      end
      ST_START: begin
        if (!cnt_zero) cnt_dec = 1'b1;
        else if (open_ok) begin
          state_d = ST_OPEN;
          cnt_ld  = timed;
          cnt_val = len_i - ONE;
        end else state_d = ST_IDLE;
      end
      ST_OPEN: begin
        if (timed) begin
          if (cnt_zero) state_d = ST_IDLE;
          else          cnt_dec = 1'b1;
        end else if (!trig_lvl) begin
          if (stop_dly_i == '0) state_d = ST_IDLE;
          else begin
            state_d = ST_HOLD;
            cnt_ld  = 1'b1;
            cnt_val = stop_dly_i - ONE;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_dec = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign gate_d = (state_d == ST_OPEN) || (state_d == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
    end

  assign gate_o      = gate_q;
  assign gate_stat_o = (state_q == ST_OPEN) || (state_q == ST_HOLD);
endmodule

// File: rtl/gate_gen_chk.sv
module gate_gen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             mode_i,
  input logic [CNT_W-1:0] len_i,
  input logic [CNT_W-1:0] start_dly_i,
  input logic [CNT_W-1:0] stop_dly_i,
  input logic             gate_o,
  input logic             gate_stat_o
);
  always @(posedge clk_i)
    if (!rst_ni) p_reset_low_r1: assert (!gate_o && !gate_stat_o);

  p_open_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) && start_dly_i == '0 |-> $past(trig_i, 3));

  p_close_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) && !mode_i && stop_dly_i == '0 |-> !$past(trig_i, 3));

  p_zero_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && len_i == '0 && !gate_o |=> !gate_o);

  p_status_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_stat_o == gate_o);
endmodule

bind gate_gen gate_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/gate_gen_tb_top.sv
module gate_gen_tb_top;
  localparam int CLK_NS = 8;
  localparam int W      = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         trig = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] len = '0, sdly = '0, pdly = '0;
  logic         gate, stat;
  int           checks = 0, fails = 0;
  bit           done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  gate_gen #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mode_i(mode),
    .len_i(len), .start_dly_i(sdly), .stop_dly_i(pdly),
    .gate_o(gate), .gate_stat_o(stat)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // expected gate after relative edge e; strobe first sampled high at edge 0
  function automatic bit exp_gate(int e, bit m, int l, int s, int p, int h);
    int op = 2 + s;
    int en = m ? op + l : h + 2 + p;
    return (e >= op) && (e < en);
  endfunction

  task automatic run_seq(bit m, int l, int s, int p, int h,
                         int t2, int h2, string tag);
    int tmax = 2 + s + ((l > h + p) ? l : h + p) + 6;
    @(negedge clk);
    mode = m; len = W'(l); sdly = W'(s); pdly = W'(p); trig = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk({tag, " idle"}, gate, 1'b0);
    end
    for (int t = 0; t <= tmax; t++) begin
      @(negedge clk);
      if (t > 0) begin
        chk(tag, gate, exp_gate(t - 1, m, l, s, p, h));
        chk("R9", stat, gate);
      end
      trig = (t < h) || (t >= t2 && t < t2 + h2);
    end
    trig = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, p, l, h;
    bit m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", gate, 1'b0);
    chk("R1", stat, 1'b0);
    rst_n = 1'b1;

    run_seq(1'b0, 0, 0, 0, 5, 999, 0, "R2");
    run_seq(1'b0, 0, 3, 0, 6, 999, 0, "R3");
    run_seq(1'b0, 9, 0, 4, 3, 999, 0, "R7");
    run_seq(1'b1, 6, 0, 9, 2, 999, 0, "R5");
    run_seq(1'b1, 4, 2, 0, 12, 999, 0, "R8");
    run_seq(1'b1, 0, 1, 3, 4, 999, 0, "R6");
    run_seq(1'b1, 10, 0, 0, 2, 5, 2, "R8");
    run_seq(1'b0, 0, 0, 10, 4, 7, 2, "R8");

    // reset in the middle of an open window
    @(negedge clk);
    mode = 1'b1; len = W'(40); sdly = '0; trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5", gate, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1", gate, 1'b0);
    chk("R1", stat, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R1", gate, 1'b0);
    end

    for (int i = 0; i < 60; i++) begin
      m = 1'($urandom_range(0, 1));
      s = $urandom_range(0, 7);
      p = $urandom_range(0, 7);
      l = $urandom_range(0, 12);
      h = s + 1 + $urandom_range(0, 9);
      run_seq(m, l, s, p, h, 999, 0, m ? ((l == 0) ? "R6" : "R5") : "R4");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule